// File: doc/BRIEF.md
# Stream-to-Video Output Bridge

This block turns a one-pixel-per-clock video stream into native parallel video: three 8-bit colour components with horizontal sync, vertical sync and a data-enable strobe. The stream arrives over a valid/ready interface whose user bit marks the first pixel of a frame and whose last bit marks the final pixel of a line. The bridge does not generate timing itself. An external timing generator supplies active-video, hsync and vsync. The bridge feeds that generator a clock-enable and holds it stalled until the stream is aligned to the start of a frame.

Incoming beats are written into a 1024-entry FIFO. While the bridge is unaligned, beats at the FIFO head that do not mark a frame start are thrown away. Once a frame-start beat is at the head and the FIFO holds at least 12 entries, the bridge releases the generator. From then on it pulls one pixel for every active-video cycle. If the FIFO runs dry during active video, or a line end in the stream falls somewhere other than the last active pixel, the bridge raises a one-cycle error pulse. It then stalls the generator again and waits for the next frame start.

Stream rules: a beat transfers on a clock edge where both valid and ready are high. Ready drops only when the FIFO is full. A source facing low ready holds its beat until ready returns.

Top module: `svb_stream_to_video`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the clock-enable, data-enable, all colour outputs and both error pulses are 0, and stream ready is 1.
- R2: Stream ready is low exactly when the FIFO holds 1024 entries. While ready is low no beat is accepted, and the FIFO level never rises.
- R3: While unlocked, a beat at the FIFO head without the user bit is discarded one per cycle and never reaches the video output.
- R4: The clock-enable rises only when a beat with the user bit is at the FIFO head and the FIFO holds at least 12 entries. With 11 entries it stays low.
- R5: While locked, each cycle with active-video high pops one beat. The next cycle shows that pixel with data-enable high, where stream bits [23:16] are red, [15:8] green and [7:0] blue.
- R6: Whenever data-enable is low, all three colour outputs are 0.
- R7: The hsync and vsync outputs equal the hsync and vsync inputs of the previous cycle, in every state.
- R8: While locked, an active-video cycle with an empty FIFO pops nothing. On the next cycle it gives a one-cycle underflow pulse and drops the clock-enable.
- R9: A line-end bit that is set on a pixel that is not the last active pixel of its line, or missing on the last active pixel, gives a one-cycle alignment pulse two cycles after that pixel is popped and drops the clock-enable. No pixel is popped in the cycle the mismatch is detected.
- R10: The clock-enable falls only together with an error pulse. Relocking after an error needs a frame-start beat at the head and 12 entries again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock for stream and video sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_axis_tdata | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |
| s_axis_tvalid | input | 1 | Stream beat valid |
| s_axis_tready | output | 1 | FIFO can accept a beat |
| s_axis_tuser | input | 1 | Beat is the first pixel of a frame |
| s_axis_tlast | input | 1 | Beat is the last pixel of a line |
| tm_active | input | 1 | Active video from the timing generator |
| tm_hsync | input | 1 | Horizontal sync from the timing generator |
| tm_vsync | input | 1 | Vertical sync from the timing generator |
| tm_ce | output | 1 | Clock-enable back to the timing generator |
| vid_r | output | 8 | Red component |
| vid_g | output | 8 | Green component |
| vid_b | output | 8 | Blue component |
| vid_hsync | output | 1 | Delayed horizontal sync |
| vid_vsync | output | 1 | Delayed vertical sync |
| vid_de | output | 1 | Pixel on the colour outputs is valid |
| err_underflow | output | 1 | One-cycle pulse: FIFO empty during active video |
| err_align | output | 1 | One-cycle pulse: line end out of place |

## Verification
The bench places the lock decision on either side of the 12-entry threshold. A bridge that releases the generator one entry early shows its clock-enable a cycle before the expected edge. It also feeds junk beats ahead of the frame start: a bridge that forwards them instead of discarding them puts a wrong colour on the first output pixel. It lets the stream run dry and moves the line-end bit both early and missing. A bridge that misses either case keeps the generator running and shows too many or too few pixels. Finally it fills the FIFO to the brim with active video held off, so an off-by-one full flag shows up in the ready level around the 1023rd and 1024th entries.

// File: rtl/svb_pkg.sv
package svb_pkg;

  typedef enum logic {
    ST_SEEK   = 1'b0,
    ST_LOCKED = 1'b1
  } svb_state_e;

  localparam int unsigned NUM_CH = 3;

endpackage

// File: rtl/svb_fifo.sv
module svb_fifo #(
  parameter int unsigned WIDTH = 26,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic [LVL_W-1:0] level
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/svb_lock_ctrl.sv
module svb_lock_ctrl
  import svb_pkg::*;
#(
  parameter int unsigned LVL_W = 11,
  parameter int unsigned HYST  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             empty,
  input  logic             head_sof,
  input  logic             head_eol,
  input  logic             vid_active,
  output logic             pop,
  output logic             take,
  output logic             gen_ce,
  output logic             err_under,
  output logic             err_align
);

  svb_state_e state_q, state_d;
  logic       locked;
  logic       chk_vld_q, chk_eol_q;
  logic       under_now, align_now, fault, drop, ready_to_lock;

  assign locked = (state_q == ST_LOCKED);
  assign gen_ce = locked;

  // The popped pixel was the last active one exactly when active video has now ended.
  assign align_now = locked && chk_vld_q && (chk_eol_q == vid_active);
  assign under_now = locked && vid_active && empty;
  assign fault     = under_now || align_now;

  assign take = locked && vid_active && !empty && !align_now;
  assign drop = !locked && !empty && !head_sof;
  assign pop  = take || drop;

  assign ready_to_lock = !empty && head_sof && (level >= LVL_W'(HYST));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEEK:   if (ready_to_lock) state_d = ST_LOCKED;
      ST_LOCKED: if (fault)         state_d = ST_SEEK;
      default:                      state_d = ST_SEEK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SEEK;
      chk_vld_q <= 1'b0;
      chk_eol_q <= 1'b0;
      err_under <= 1'b0;
      err_align <= 1'b0;
    end else begin
      state_q   <= state_d;
      chk_vld_q <= take;
      chk_eol_q <= take && head_eol;
      err_under <= under_now;
      err_align <= align_now;
    end
  end

endmodule

// File: rtl/svb_pixel_out.sv
module svb_pixel_out
  import svb_pkg::*;
#(
  parameter int unsigned COMP_W = 8,
  parameter int unsigned PIX_W  = NUM_CH * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [PIX_W-1:0]  pix,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic [COMP_W-1:0] out_r,
  output logic [COMP_W-1:0] out_g,
  output logic [COMP_W-1:0] out_b,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic              out_de
);

  // Channel 0 is blue in the low bits, channel NUM_CH-1 is red in the high bits.
  logic [COMP_W-1:0] comp_q [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) comp_q[c] <= '0;
      out_de    <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        comp_q[c] <= take ? pix[c*COMP_W +: COMP_W] : '0;
      out_de    <= take;
      out_hsync <= hsync_in;
      out_vsync <= vsync_in;
    end
  end

  assign out_b = comp_q[0];
  assign out_g = comp_q[1];
  assign out_r = comp_q[2];

endmodule

// File: rtl/svb_stream_to_video.sv
module svb_stream_to_video
  import svb_pkg::*;
#(
  parameter int unsigned COMP_W     = 8,
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned HYST_LEVEL = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*COMP_W-1:0] s_axis_tdata,
  input  logic                     s_axis_tvalid,
  output logic                     s_axis_tready,
  input  logic                     s_axis_tuser,
  input  logic                     s_axis_tlast,
  input  logic                     tm_active,
  input  logic                     tm_hsync,
  input  logic                     tm_vsync,
  output logic                     tm_ce,
  output logic [COMP_W-1:0]        vid_r,
  output logic [COMP_W-1:0]        vid_g,
  output logic [COMP_W-1:0]        vid_b,
  output logic                     vid_hsync,
  output logic                     vid_vsync,
  output logic                     vid_de,
  output logic                     err_underflow,
  output logic                     err_align
);

  localparam int unsigned PIX_W   = NUM_CH * COMP_W;
  localparam int unsigned ENTRY_W = PIX_W + 2;
  localparam int unsigned EOL_BIT = PIX_W;
  localparam int unsigned SOF_BIT = PIX_W + 1;
  localparam int unsigned LVL_W   = $clog2(FIFO_DEPTH + 1);

  logic [ENTRY_W-1:0] wr_entry, head_entry;
  logic [LVL_W-1:0]   fill_level;
  logic               fifo_full, fifo_empty;
  logic               pop, take;

  assign wr_entry      = {s_axis_tuser, s_axis_tlast, s_axis_tdata};
  assign s_axis_tready = !fifo_full;

  svb_fifo #(
    .WIDTH(ENTRY_W),
    .DEPTH(FIFO_DEPTH),
    .LVL_W(LVL_W)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (s_axis_tvalid),
    .wr_data(wr_entry),
    .full   (fifo_full),
    .rd_en  (pop),
    .rd_data(head_entry),
    .empty  (fifo_empty),
    .level  (fill_level)
  );

  svb_lock_ctrl #(
    .LVL_W(LVL_W),
    .HYST (HYST_LEVEL)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (fill_level),
    .empty     (fifo_empty),
    .head_sof  (head_entry[SOF_BIT]),
    .head_eol  (head_entry[EOL_BIT]),
    .vid_active(tm_active),
    .pop       (pop),
    .take      (take),
    .gen_ce    (tm_ce),
    .err_under (err_underflow),
    .err_align (err_align)
  );

  svb_pixel_out #(
    .COMP_W(COMP_W),
    .PIX_W (PIX_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .pix      (head_entry[PIX_W-1:0]),
    .hsync_in (tm_hsync),
    .vsync_in (tm_vsync),
    .out_r    (vid_r),
    .out_g    (vid_g),
    .out_b    (vid_b),
    .out_hsync(vid_hsync),
    .out_vsync(vid_vsync),
    .out_de   (vid_de)
  );

endmodule

// File: rtl/svb_checker.sv
module svb_checker #(
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned HYST   = 12,
  parameter int unsigned LVL_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tready,
  input logic              tm_active,
  input logic              tm_hsync,
  input logic              tm_vsync,
  input logic              tm_ce,
  input logic [COMP_W-1:0] vid_r,
  input logic [COMP_W-1:0] vid_g,
  input logic [COMP_W-1:0] vid_b,
  input logic              vid_hsync,
  input logic              vid_vsync,
  input logic              vid_de,
  input logic              err_underflow,
  input logic              err_align,
  input logic [LVL_W-1:0]  fill_level
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tm_ce && !vid_de && !err_underflow && !err_align));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live && !s_tready |=> fill_level <= $past(fill_level));

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH));

  p_lock_hyst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live && $rose(tm_ce) |-> $past(fill_level) >= LVL_W'(HYST));

  p_de_in_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && vid_de |-> ($past(tm_active) && $past(tm_ce)));

  p_blank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_de |-> (vid_r == '0 && vid_g == '0 && vid_b == '0));

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (vid_hsync == $past(tm_hsync) && vid_vsync == $past(tm_vsync)));

  p_under_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> !tm_ce);

  p_align_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> !tm_ce);

  p_ce_fall_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live && $fell(tm_ce) |-> (err_underflow || err_align));

endmodule

bind svb_stream_to_video svb_checker #(
  .COMP_W(COMP_W),
  .DEPTH (FIFO_DEPTH),
  .HYST  (HYST_LEVEL),
  .LVL_W (LVL_W)
) u_svb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_tready     (s_axis_tready),
  .tm_active    (tm_active),
  .tm_hsync     (tm_hsync),
  .tm_vsync     (tm_vsync),
  .tm_ce        (tm_ce),
  .vid_r        (vid_r),
  .vid_g        (vid_g),
  .vid_b        (vid_b),
  .vid_hsync    (vid_hsync),
  .vid_vsync    (vid_vsync),
  .vid_de       (vid_de),
  .err_underflow(err_underflow),
  .err_align    (err_align),
  .fill_level   (fill_level)
);

// File: tb/tb_svb_stream_to_video.sv
`timescale 1ns/1ps
module tb_svb_stream_to_video;

  localparam int HA = 8, HT = 12, HS0 = 9, HS1 = 11;
  localparam int VA = 3, VT = 5, VS0 = 3, VS1 = 4;
  localparam int DEPTH = 1024;

  // Stimulus/expected table: colour per column, line index folded into bits [7:4].
  localparam logic [23:0] BARS [8] = '{
    24'hE01010, 24'h10E010, 24'h1010E0, 24'hE0E010,
    24'h10E0E0, 24'hE010E0, 24'hF0F0F0, 24'h202020
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [23:0] s_tdata = '0;
  logic        s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
  logic        s_tready;
  logic        tm_active, tm_hsync, tm_vsync, tm_ce;
  logic [7:0]  vid_r, vid_g, vid_b;
  logic        vid_hsync, vid_vsync, vid_de, err_underflow, err_align;

  svb_stream_to_video dut (
    .clk(clk), .rst_n(rst_n),
    .s_axis_tdata(s_tdata), .s_axis_tvalid(s_tvalid), .s_axis_tready(s_tready),
    .s_axis_tuser(s_tuser), .s_axis_tlast(s_tlast),
    .tm_active(tm_active), .tm_hsync(tm_hsync), .tm_vsync(tm_vsync), .tm_ce(tm_ce),
    .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
    .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_de(vid_de),
    .err_underflow(err_underflow), .err_align(err_align)
  );

  // Bench timing generator, advanced by the bridge's clock-enable.
  int   gh = 0, gv = 0;
  logic gen_clr = 1'b0, man_hold = 1'b0;
  always_ff @(posedge clk) begin
    if (gen_clr) begin
      gh <= 0; gv <= 0;
    end else if (tm_ce) begin
      if (gh == HT - 1) begin
        gh <= 0;
        gv <= (gv == VT - 1) ? 0 : gv + 1;
      end else gh <= gh + 1;
    end
  end
  assign tm_active = !man_hold && (gh < HA) && (gv < VA);
  assign tm_hsync  = (gh >= HS0) && (gh < HS1);
  assign tm_vsync  = (gv >= VS0) && (gv < VS1);

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pix(input int x, input int y);
    return BARS[x] ^ 24'(y << 4);
  endfunction

  // Output monitor.
  int   exp_k = 0, uf_cnt = 0, al_cnt = 0;
  bit   have_prev = 0;
  logic prev_hs, prev_vs;
  always @(negedge clk) begin
    if (rst_n) begin
      if (have_prev)
        chk({vid_hsync, vid_vsync} == {prev_hs, prev_vs}, "R7", "sync delay",
            {vid_hsync, vid_vsync}, {prev_hs, prev_vs});
      prev_hs = tm_hsync; prev_vs = tm_vsync; have_prev = 1;
      if (vid_de) begin
        chk({vid_r, vid_g, vid_b} == pix(exp_k % 8, (exp_k / 8) % 3), "R5",
            "pixel value", {vid_r, vid_g, vid_b}, pix(exp_k % 8, (exp_k / 8) % 3));
        exp_k++;
      end else begin
        chk({vid_r, vid_g, vid_b} == 24'h0, "R6", "blank colour",
            {vid_r, vid_g, vid_b}, 0);
      end
      if (err_underflow) uf_cnt++;
      if (err_align) al_cnt++;
    end else have_prev = 0;
  end

  task automatic push(input logic [23:0] d, input bit u, input bit l);
    s_tdata = d; s_tuser = u; s_tlast = l; s_tvalid = 1'b1;
    while (!s_tready) @(negedge clk);
    @(negedge clk);
    s_tvalid = 1'b0;
  endtask

  // Beat k of a frame (8 per line); tlast on column last_x (-1: never).
  task automatic send_beat(input int k, input int last_x);
    push(pix(k % 8, k / 8), k == 0, (k % 8) == last_x);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_gen();
    gen_clr = 1'b1; @(negedge clk); gen_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(tm_ce == 0 && vid_de == 0, "R1", "ce/de in reset", {tm_ce, vid_de}, 0);
    chk({vid_r, vid_g, vid_b} == 0, "R1", "colour in reset", {vid_r, vid_g, vid_b}, 0);
    chk(err_underflow == 0 && err_align == 0, "R1", "errors in reset",
        {err_underflow, err_align}, 0);
    chk(s_tready == 1, "R1", "ready in reset", s_tready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tm_ce == 0 && vid_de == 0, "R1", "idle after reset", {tm_ce, vid_de}, 0);

    // R3: junk ahead of frame start is discarded; R4: 11 entries hold the lock off
    for (int j = 0; j < 3; j++) push(24'hABCDEF, 1'b0, 1'b0);
    for (int k = 0; k < 11; k++) send_beat(k, 7);
    repeat (3) @(negedge clk);
    chk(tm_ce == 0, "R4", "ce with 11 entries", tm_ce, 0);
    send_beat(11, 7);
    chk(tm_ce == 0, "R4", "ce on the edge that wrote entry 12", tm_ce, 0);
    @(negedge clk);
    chk(tm_ce == 1, "R4", "ce with 12 entries", tm_ce, 1);

    // R5: stream two whole frames through the table loop, then run dry
    for (int k = 12; k < 24; k++) send_beat(k, 7);
    for (int k = 0; k < 24; k++) send_beat(k, 7);
    for (int i = 0; i < 300 && uf_cnt == 0; i++) @(negedge clk);
    chk(exp_k == 48, "R5", "pixels in two frames", exp_k, 48);
    chk(uf_cnt == 1, "R8", "underflow pulses", uf_cnt, 1);
    chk(tm_ce == 0, "R8", "ce after underflow", tm_ce, 0);
    chk(al_cnt == 0, "R9", "no alignment error on clean frames", al_cnt, 0);
    repeat (4) @(negedge clk);
    chk(exp_k == 48 && uf_cnt == 1, "R8", "no pop while dry", exp_k, 48);

    // R10 relock after error, then R9 early line end on line 1 column 5
    clear_gen();
    exp_k = 0;
    for (int k = 0; k < 11; k++) send_beat(k, 7);
    repeat (3) @(negedge clk);
    chk(tm_ce == 0, "R10", "relock needs 12 entries", tm_ce, 0);
    send_beat(11, 7);
    @(negedge clk);
    chk(tm_ce == 1, "R10", "relocked", tm_ce, 1);
    for (int k = 12; k < 16; k++) send_beat(k, (k < 8) ? 7 : 5);
    for (int i = 0; i < 200 && al_cnt == 0; i++) @(negedge clk);
    chk(al_cnt == 1, "R9", "early line end flagged", al_cnt, 1);
    chk(tm_ce == 0, "R9", "ce after early line end", tm_ce, 0);
    chk(exp_k == 14, "R9", "pixels before early-end error", exp_k, 14);

    // R9: line end missing on the last active pixel
    repeat (20) @(negedge clk);
    clear_gen();
    exp_k = 0;
    for (int k = 0; k < 16; k++) send_beat(k, (k < 8) ? -1 : 7);
    for (int i = 0; i < 200 && al_cnt == 1; i++) @(negedge clk);
    chk(al_cnt == 2, "R9", "missing line end flagged", al_cnt, 2);
    chk(exp_k == 8, "R9", "pixels before missing-end error", exp_k, 8);
    chk(uf_cnt == 1, "R8", "no extra underflow", uf_cnt, 1);

    // R2: fill the FIFO with active video held off
    repeat (20) @(negedge clk);
    do_reset();
    man_hold = 1'b1;
    clear_gen();
    exp_k = 0;
    send_beat(0, 7);
    for (int k = 1; k < DEPTH - 1; k++) send_beat(k % 24, 7);
    chk(s_tready == 1, "R2", "ready at 1023 entries", s_tready, 1);
    chk(tm_ce == 1, "R4", "locked with sof and full level", tm_ce, 1);
    send_beat(5, 7);
    chk(s_tready == 0, "R2", "ready at 1024 entries", s_tready, 0);
    s_tvalid = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_tready == 0, "R2", "ready held low while full", s_tready, 0);
    chk(vid_de == 0 && exp_k == 0, "R6", "no output with active held off", vid_de, 0);
    s_tvalid = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule